// File: doc/BRIEF.md
# MAC Control Register Bank

This block is the software-visible control register bank of an Ethernet MAC. It sits on a simple 32-bit read/write slave bus. It holds the operating mode, the interrupt status and mask, the three inter-packet gap settings, the frame length limits, the collision settings, the transmit descriptor count, the management interface registers, the six-byte station address and the 64-bit multicast hash. It also gives the bus a window onto a word-addressed descriptor memory.

The transmit and receive engines are separate blocks. They read the decoded fields straight from this bank's output ports. They report events through a per-bit set input, and they start or stop on one-cycle pulses that the bank raises when a mode write changes an enable bit.

Software can put the whole bank back to its power-up state by writing the self-reset bit of the mode register. Descriptor memory contents are kept across a self-reset.

Top module: `emac_regbank`

## Requirements
- R1: After `rst`, the registers read back as follows: mode 0x0000A000, IPG-transmit 0x12, IPG-receive-1 0x0C, IPG-receive-2 0x12, frame length 0x003C0600, collision 0x000F003F, management mode 0x64, transmit descriptor count 0x40. Every other register reads 0.
- R2: A read is issued by holding `rd_en` for one cycle. `rvalid` is high for exactly the next cycle, and `rdata` is valid in that cycle. `rvalid` is low in every cycle that does not follow a read.
- R3: The interrupt status register (offset 0x04, 7 bits) is write-one-to-clear. Each bit written as 1 clears, and each bit written as 0 is kept. A bit raised on `evt_set` in the same cycle as a clear of that bit stays set.
- R4: A write to the transmit descriptor count (offset 0x20) stores only `wdata[7:0]`. The same write loads the receive ring index `rx_ring_idx_o` with that byte shifted left by one, so the reset value of the index is 0x080.
- R5: A mode write with bit 11 set returns every register, and the receive ring index, to its R1 value one cycle later. Descriptor memory contents are kept.
- R6: Station register 0 (offset 0x40) holds address bytes 0..3, with byte 0 in bits 7:0. Station register 1 (offset 0x44) holds byte 4 in bits 7:0 and byte 5 in bits 15:8, and stores only those 16 bits. `station_addr_o[8k+7:8k]` is byte k.
- R7: Byte offsets 0x400 to 0x5FC address descriptor memory word (offset − 0x400)/4. Each word is independently writable and readable.
- R8: Mode bit 0 enables receive and bit 1 enables transmit. A mode write that takes an enable bit from 0 to 1 raises that engine's start pulse for one cycle. A mode write that takes it from 1 to 0, including a self-reset, raises that engine's stop pulse for one cycle. A write that leaves the bit unchanged raises neither pulse.
- R9: Unmapped offsets read 0 and ignore writes. Unmapped means offsets 0x50 to 0x3FC, offsets from 0x600 up, and any address with `addr[1:0]` non-zero.
- R10: The registers sit at offsets 0x00 upward in steps of 4 in this order: mode, interrupt status, interrupt mask, IPG-transmit, IPG-receive-1, IPG-receive-2, frame length, collision, transmit descriptor count, control mode, management mode, management command, management address, management transmit data, management receive data, management status, station 0, station 1, hash low, hash high. The interrupt mask keeps 7 bits. `hash_o` is {hash high, hash low}.
- R11: `min_len_o` is frame length bits 31:16 and `max_len_o` is bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 11 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| evt_set | input | 7 | Interrupt status set bits from the engines |
| mode_o | output | 32 | Mode register |
| int_src_o | output | 7 | Interrupt status |
| int_mask_o | output | 7 | Interrupt mask |
| ipgt_o | output | 7 | Transmit inter-packet gap |
| ipgr1_o | output | 7 | Receive inter-packet gap, part 1 |
| ipgr2_o | output | 7 | Receive inter-packet gap, part 2 |
| min_len_o | output | 16 | Minimum frame length |
| max_len_o | output | 16 | Maximum frame length |
| coll_cfg_o | output | 32 | Collision configuration |
| tx_bd_cnt_o | output | 8 | Transmit descriptor count |
| rx_ring_idx_o | output | 9 | Receive ring starting index |
| station_addr_o | output | 48 | Station address, byte k at bits 8k+7:8k |
| hash_o | output | 64 | Multicast hash |
| rx_start_o | output | 1 | Receive engine start pulse |
| rx_stop_o | output | 1 | Receive engine stop pulse |
| tx_start_o | output | 1 | Transmit engine start pulse |
| tx_stop_o | output | 1 | Transmit engine stop pulse |

## Verification
Almost all of the bank's state is visible on its output ports one cycle after the write that changes it. A corrupted interrupt status or descriptor count, or a wrong ring reload, therefore shows on `int_src_o`, `tx_bd_cnt_o` or `rx_ring_idx_o` in the following cycle. A fault in the read path shows two cycles after the write, as a wrong word alongside `rvalid`. A missed or duplicated start or stop pulse is caught in the single cycle after the mode write. The engines would act on a wrong pulse at once, so pulse checks sample exactly that cycle. Aliasing faults in the address decode only appear when a later read returns a word that an unmapped or misaligned write should not have touched. For that reason the bench reads back neighbouring locations after each such write.

// File: rtl/emac_regbank_pkg.sv
package emac_regbank_pkg;

    localparam int NREG     = 20;
    localparam int REG_AW   = 5;
    localparam int INT_W    = 7;
    localparam int MODE_RXEN = 0;
    localparam int MODE_TXEN = 1;
    localparam int MODE_RST  = 11;

    localparam logic [REG_AW-1:0] IDX_MODE     = 5'd0;
    localparam logic [REG_AW-1:0] IDX_INT_SRC  = 5'd1;
    localparam logic [REG_AW-1:0] IDX_INT_MASK = 5'd2;
    localparam logic [REG_AW-1:0] IDX_IPGT     = 5'd3;
    localparam logic [REG_AW-1:0] IDX_IPGR1    = 5'd4;
    localparam logic [REG_AW-1:0] IDX_IPGR2    = 5'd5;
    localparam logic [REG_AW-1:0] IDX_PKTLEN   = 5'd6;
    localparam logic [REG_AW-1:0] IDX_COLL     = 5'd7;
    localparam logic [REG_AW-1:0] IDX_TXBD     = 5'd8;
    localparam logic [REG_AW-1:0] IDX_CTRL     = 5'd9;
    localparam logic [REG_AW-1:0] IDX_MGMT_MOD = 5'd10;
    localparam logic [REG_AW-1:0] IDX_MGMT_CMD = 5'd11;
    localparam logic [REG_AW-1:0] IDX_MGMT_ADR = 5'd12;
    localparam logic [REG_AW-1:0] IDX_MGMT_TXD = 5'd13;
    localparam logic [REG_AW-1:0] IDX_MGMT_RXD = 5'd14;
    localparam logic [REG_AW-1:0] IDX_MGMT_STS = 5'd15;
    localparam logic [REG_AW-1:0] IDX_STA0     = 5'd16;
    localparam logic [REG_AW-1:0] IDX_STA1     = 5'd17;
    localparam logic [REG_AW-1:0] IDX_HASH_LO  = 5'd18;
    localparam logic [REG_AW-1:0] IDX_HASH_HI  = 5'd19;

    localparam logic [7:0] TXBD_RESET = 8'h40;
    localparam logic [8:0] RING_RESET = {TXBD_RESET, 1'b0};

    typedef struct packed {
        logic              hit;
        logic [REG_AW-1:0] idx;
    } reg_sel_t;

    typedef struct packed {
        logic rx_start;
        logic rx_stop;
        logic tx_start;
        logic tx_stop;
    } eng_pulse_t;

    function automatic logic [31:0] reg_reset(input logic [REG_AW-1:0] idx);
        case (idx)
            IDX_MODE:     return 32'h0000_A000;
            IDX_IPGT:     return 32'h0000_0012;
            IDX_IPGR1:    return 32'h0000_000C;
            IDX_IPGR2:    return 32'h0000_0012;
            IDX_PKTLEN:   return 32'h003C_0600;
            IDX_COLL:     return 32'h000F_003F;
            IDX_MGMT_MOD: return 32'h0000_0064;
            IDX_TXBD:     return {24'h0, TXBD_RESET};
            default:      return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] reg_mask(input logic [REG_AW-1:0] idx);
        case (idx)
            IDX_MODE:     return 32'h0001_F7FF;
            IDX_INT_SRC,
            IDX_INT_MASK,
            IDX_IPGT,
            IDX_IPGR1,
            IDX_IPGR2:    return 32'h0000_007F;
            IDX_COLL:     return 32'h003F_003F;
            IDX_TXBD:     return 32'h0000_00FF;
            IDX_CTRL,
            IDX_MGMT_CMD,
            IDX_MGMT_STS: return 32'h0000_0007;
            IDX_MGMT_MOD: return 32'h0000_01FF;
            IDX_MGMT_ADR: return 32'h0000_1F1F;
            IDX_MGMT_TXD,
            IDX_MGMT_RXD,
            IDX_STA1:     return 32'h0000_FFFF;
            default:      return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/emac_rb_decode.sv
module emac_rb_decode
    import emac_regbank_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int BD_BASE  = 'h400,
    parameter int BD_WORDS = 128,
    localparam int BD_AW   = $clog2(BD_WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel,
    output logic              bd_hit,
    output logic [BD_AW-1:0]  bd_idx
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] BD_FIRST = WORD_W'(BD_BASE / 4);
    localparam logic [WORD_W-1:0] BD_END   = WORD_W'(BD_BASE / 4 + BD_WORDS);

    logic [WORD_W-1:0] word;
    logic              aligned;

    always_comb begin
        word    = addr[ADDR_W-1:2];
        aligned = (addr[1:0] == 2'b00);
        sel.hit = aligned && (word < WORD_W'(NREG));
        sel.idx = word[REG_AW-1:0];
        bd_hit  = aligned && (word >= BD_FIRST) && (word < BD_END);
        bd_idx  = BD_AW'(word - BD_FIRST);
    end
endmodule

// File: rtl/emac_rb_bdram.sv
module emac_rb_bdram #(
    parameter int WORDS = 128,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] idx,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata
);
    logic [31:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
        if (re) rdata <= mem[idx];
    end
endmodule

// File: rtl/emac_rb_regs.sv
module emac_rb_regs
    import emac_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  reg_sel_t          sel,
    input  logic [31:0]       wdata,
    input  logic [INT_W-1:0]  evt_set,
    output logic [31:0]       rd_word,
    output logic [31:0]       mode,
    output logic [INT_W-1:0]  int_src,
    output logic [INT_W-1:0]  int_mask,
    output logic [6:0]        ipgt,
    output logic [6:0]        ipgr1,
    output logic [6:0]        ipgr2,
    output logic [31:0]       pktlen,
    output logic [31:0]       coll,
    output logic [7:0]        txbd,
    output logic [47:0]       station,
    output logic [63:0]       hash,
    output logic [8:0]        ring_idx,
    output eng_pulse_t        pulse
);
    logic [NREG-1:0][31:0] regq;
    logic                  wr_hit;
    logic                  mode_wr;
    logic                  soft_rst;
    logic [31:0]           mode_next;
    logic [31:0]           evt_word;

    assign wr_hit    = we && sel.hit;
    assign mode_wr   = wr_hit && (sel.idx == IDX_MODE);
    assign soft_rst  = mode_wr && wdata[MODE_RST];
    assign mode_next = soft_rst ? reg_reset(IDX_MODE) : (wdata & reg_mask(IDX_MODE));
    assign evt_word  = {{(32-INT_W){1'b0}}, evt_set};

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [REG_AW-1:0] IDX = REG_AW'(i);
        localparam logic [31:0] RVAL = reg_reset(IDX);
        localparam logic [31:0] MSK  = reg_mask(IDX);
        logic [31:0] q;

        if (IDX == IDX_INT_SRC) begin : g_w1c
            always_ff @(posedge clk) begin
                if (rst || soft_rst)
                    q <= RVAL;
                else if (wr_hit && sel.idx == IDX)
                    q <= (q & ~(wdata & MSK)) | (evt_word & MSK);
                else
                    q <= q | (evt_word & MSK);
            end
        end else begin : g_rw
            always_ff @(posedge clk) begin
                if (rst || soft_rst)
                    q <= RVAL;
                else if (wr_hit && sel.idx == IDX)
                    q <= wdata & MSK;
            end
        end

        assign regq[i] = q;
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst)
            ring_idx <= RING_RESET;
        else if (wr_hit && sel.idx == IDX_TXBD)
            ring_idx <= {wdata[7:0], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse <= '0;
        end else if (mode_wr) begin
            pulse.rx_start <=  mode_next[MODE_RXEN] && !mode[MODE_RXEN];
            pulse.rx_stop  <= !mode_next[MODE_RXEN] &&  mode[MODE_RXEN];
            pulse.tx_start <=  mode_next[MODE_TXEN] && !mode[MODE_TXEN];
            pulse.tx_stop  <= !mode_next[MODE_TXEN] &&  mode[MODE_TXEN];
        end else begin
            pulse <= '0;
        end
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NREG; i++)
            if (sel.hit && sel.idx == REG_AW'(i)) rd_word = regq[i];
    end

    assign mode     = regq[IDX_MODE];
    assign int_src  = regq[IDX_INT_SRC][INT_W-1:0];
    assign int_mask = regq[IDX_INT_MASK][INT_W-1:0];
    assign ipgt     = regq[IDX_IPGT][6:0];
    assign ipgr1    = regq[IDX_IPGR1][6:0];
    assign ipgr2    = regq[IDX_IPGR2][6:0];
    assign pktlen   = regq[IDX_PKTLEN];
    assign coll     = regq[IDX_COLL];
    assign txbd     = regq[IDX_TXBD][7:0];
    assign station  = {regq[IDX_STA1][15:0], regq[IDX_STA0]};
    assign hash     = {regq[IDX_HASH_HI], regq[IDX_HASH_LO]};
endmodule

// File: rtl/emac_regbank.sv
module emac_regbank
    import emac_regbank_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int BD_BASE  = 'h400,
    parameter int BD_WORDS = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              rvalid,
    input  logic [INT_W-1:0]  evt_set,
    output logic [31:0]       mode_o,
    output logic [INT_W-1:0]  int_src_o,
    output logic [INT_W-1:0]  int_mask_o,
    output logic [6:0]        ipgt_o,
    output logic [6:0]        ipgr1_o,
    output logic [6:0]        ipgr2_o,
    output logic [15:0]       min_len_o,
    output logic [15:0]       max_len_o,
    output logic [31:0]       coll_cfg_o,
    output logic [7:0]        tx_bd_cnt_o,
    output logic [8:0]        rx_ring_idx_o,
    output logic [47:0]       station_addr_o,
    output logic [63:0]       hash_o,
    output logic              rx_start_o,
    output logic              rx_stop_o,
    output logic              tx_start_o,
    output logic              tx_stop_o
);
    localparam int BD_AW = $clog2(BD_WORDS);

    reg_sel_t          sel;
    logic              bd_hit;
    logic [BD_AW-1:0]  bd_idx;
    logic [31:0]       reg_word;
    logic [31:0]       bd_word;
    logic [31:0]       pktlen;
    logic [31:0]       reg_rd_q;
    logic              sel_bd_q;
    eng_pulse_t        pulse;

    emac_rb_decode #(
        .ADDR_W  (ADDR_W),
        .BD_BASE (BD_BASE),
        .BD_WORDS(BD_WORDS)
    ) u_decode (
        .addr  (addr),
        .sel   (sel),
        .bd_hit(bd_hit),
        .bd_idx(bd_idx)
    );

    emac_rb_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en),
        .sel     (sel),
        .wdata   (wdata),
        .evt_set (evt_set),
        .rd_word (reg_word),
        .mode    (mode_o),
        .int_src (int_src_o),
        .int_mask(int_mask_o),
        .ipgt    (ipgt_o),
        .ipgr1   (ipgr1_o),
        .ipgr2   (ipgr2_o),
        .pktlen  (pktlen),
        .coll    (coll_cfg_o),
        .txbd    (tx_bd_cnt_o),
        .station (station_addr_o),
        .hash    (hash_o),
        .ring_idx(rx_ring_idx_o),
        .pulse   (pulse)
    );

    emac_rb_bdram #(
        .WORDS(BD_WORDS)
    ) u_bdram (
        .clk  (clk),
        .we   (wr_en && bd_hit),
        .re   (rd_en && bd_hit),
        .idx  (bd_idx),
        .wdata(wdata),
        .rdata(bd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid   <= 1'b0;
            sel_bd_q <= 1'b0;
            reg_rd_q <= '0;
        end else begin
            rvalid   <= rd_en;
            sel_bd_q <= rd_en && bd_hit;
            if (rd_en) reg_rd_q <= reg_word;
        end
    end

    assign rdata      = sel_bd_q ? bd_word : reg_rd_q;
    assign min_len_o  = pktlen[31:16];
    assign max_len_o  = pktlen[15:0];
    assign rx_start_o = pulse.rx_start;
    assign rx_stop_o  = pulse.rx_stop;
    assign tx_start_o = pulse.tx_start;
    assign tx_stop_o  = pulse.tx_stop;
endmodule

// File: rtl/emac_regbank_chk.sv
module emac_regbank_chk
    import emac_regbank_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic              rvalid,
    input logic [INT_W-1:0]  evt_set,
    input logic [31:0]       mode_o,
    input logic [INT_W-1:0]  int_src_o,
    input logic [INT_W-1:0]  int_mask_o,
    input logic [7:0]        tx_bd_cnt_o,
    input logic [8:0]        rx_ring_idx_o,
    input logic              rx_start_o,
    input logic              rx_stop_o,
    input logic              tx_start_o,
    input logic              tx_stop_o
);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'('h00);
    localparam logic [ADDR_W-1:0] A_ISRC = ADDR_W'('h04);
    localparam logic [ADDR_W-1:0] A_TXBD = ADDR_W'('h20);

    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rvalid); // R2
    AST_RVALID_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rvalid); // R2
    AST_INT_W1C: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_ISRC && evt_set == '0)
        |=> int_src_o == ($past(int_src_o) & ~$past(wdata[INT_W-1:0]))); // R3
    AST_RING_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_TXBD)
        |=> (tx_bd_cnt_o == $past(wdata[7:0]) && rx_ring_idx_o == {$past(wdata[7:0]), 1'b0})); // R4
    AST_SELF_RESET: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_MODE && wdata[MODE_RST])
        |=> (mode_o == 32'h0000_A000 && tx_bd_cnt_o == 8'h40 && int_mask_o == '0
             && rx_ring_idx_o == 9'h080)); // R5
    AST_TX_START_EDGE: assert property (@(posedge clk) disable iff (rst)
        tx_start_o |-> (mode_o[MODE_TXEN] && !$past(mode_o[MODE_TXEN]))); // R8
    AST_RX_START_EDGE: assert property (@(posedge clk) disable iff (rst)
        rx_start_o |-> (mode_o[MODE_RXEN] && !$past(mode_o[MODE_RXEN]))); // R8
    AST_TX_STOP_EDGE: assert property (@(posedge clk) disable iff (rst)
        tx_stop_o |-> (!mode_o[MODE_TXEN] && $past(mode_o[MODE_TXEN]))); // R8
    AST_RX_STOP_EDGE: assert property (@(posedge clk) disable iff (rst)
        rx_stop_o |-> (!mode_o[MODE_RXEN] && $past(mode_o[MODE_RXEN]))); // R8
    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tx_start_o, tx_stop_o}) && $onehot0({rx_start_o, rx_stop_o})); // R8
endmodule

bind emac_regbank emac_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/emac_regbank_bench.sv
`timescale 1ns/1ps
module emac_regbank_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [10:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [6:0]  evt_set = '0;
    logic [31:0] rdata;
    logic        rvalid;
    logic [31:0] mode_o;
    logic [6:0]  int_src_o, int_mask_o, ipgt_o, ipgr1_o, ipgr2_o;
    logic [15:0] min_len_o, max_len_o;
    logic [31:0] coll_cfg_o;
    logic [7:0]  tx_bd_cnt_o;
    logic [8:0]  rx_ring_idx_o;
    logic [47:0] station_addr_o;
    logic [63:0] hash_o;
    logic        rx_start_o, rx_stop_o, tx_start_o, tx_stop_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    emac_regbank u_emac_regbank (.*);

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected read words as the design returns them.
    always @(negedge clk) begin
        if (!rst && rvalid) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected rvalid", 64'(rvalid), 64'd0);
            end else begin
                check(tag_q.pop_front(), 64'(rdata), 64'(exp_q.pop_front()));
            end
        end
    end

    task automatic bus_write(input logic [10:0] a, input logic [31:0] d, input logic [6:0] ev = '0);
        wr_en = 1'b1; addr = a; wdata = d; evt_set = ev;
        @(posedge clk); #1;
        wr_en = 1'b0; evt_set = '0;
    endtask

    task automatic bus_read(input logic [10:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        rd_en = 1'b1; addr = a;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic raise_events(input logic [6:0] ev);
        evt_set = ev;
        @(posedge clk); #1;
        evt_set = '0;
    endtask

    task automatic drain();
        repeat (3) @(posedge clk);
        #1;
        check("R2 pending reads drained", 64'(exp_q.size()), 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks + 1, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset values, R11 length fields
        check("R2 rvalid low at idle", 64'(rvalid), 64'd0);
        bus_read(11'h000, 32'h0000_A000, "R1 mode");
        bus_read(11'h00C, 32'h12, "R1 ipgt");
        bus_read(11'h010, 32'h0C, "R1 ipgr1");
        bus_read(11'h014, 32'h12, "R1 ipgr2");
        bus_read(11'h018, 32'h003C_0600, "R1 pktlen");
        bus_read(11'h01C, 32'h000F_003F, "R1 collconf");
        bus_read(11'h020, 32'h40, "R1 txbd");
        bus_read(11'h028, 32'h64, "R1 mgmt mode");
        bus_read(11'h008, 32'h0, "R1 int mask");
        bus_read(11'h048, 32'h0, "R1 hash low");
        drain();
        check("R2 rvalid low after reads", 64'(rvalid), 64'd0);
        check("R11 min_len", 64'(min_len_o), 64'h3C);
        check("R11 max_len", 64'(max_len_o), 64'h600);
        check("R4 ring idx reset", 64'(rx_ring_idx_o), 64'h080);
        check("R8 no pulses after reset", 64'({rx_start_o, rx_stop_o, tx_start_o, tx_stop_o}), 64'd0);

        // R10 offsets and field widths
        bus_write(11'h008, 32'hFFFF_FFFF);
        bus_write(11'h048, 32'hDEAD_BEEF);
        bus_write(11'h04C, 32'h0123_4567);
        bus_write(11'h030, 32'h0000_1234);
        bus_read(11'h008, 32'h7F, "R10 int mask 7 bits");
        bus_read(11'h030, 32'h1214, "R10 mgmt address");
        drain();
        check("R10 hash output", hash_o, 64'h0123_4567_DEAD_BEEF);
        check("R10 int mask port", 64'(int_mask_o), 64'h7F);

        // R11 after write
        bus_write(11'h018, 32'h0040_0500);
        check("R11 min_len write", 64'(min_len_o), 64'h40);
        check("R11 max_len write", 64'(max_len_o), 64'h500);

        // R3 write-one-to-clear
        raise_events(7'h7F);
        check("R3 events set", 64'(int_src_o), 64'h7F);
        bus_write(11'h004, 32'h0000_0005);
        check("R3 clear selected bits", 64'(int_src_o), 64'h7A);
        bus_write(11'h004, 32'h0000_0003, 7'h01);
        check("R3 set wins over clear", 64'(int_src_o), 64'h79);
        bus_read(11'h004, 32'h79, "R3 readback");
        drain();

        // R4 descriptor count and ring reload
        bus_write(11'h020, 32'h0001_2345);
        check("R4 ring idx reload", 64'(rx_ring_idx_o), 64'h08A);
        check("R4 count port", 64'(tx_bd_cnt_o), 64'h45);
        bus_read(11'h020, 32'h45, "R4 readback low byte");
        drain();

        // R6 station address
        bus_write(11'h040, 32'h4433_2211);
        bus_write(11'h044, 32'hFFFF_6655);
        check("R6 station port", 64'(station_addr_o), 64'h6655_4433_2211);
        bus_read(11'h044, 32'h6655, "R6 station reg 1 16 bits");
        drain();

        // R7 descriptor window
        bus_write(11'h400, 32'hA5A5_0001);
        bus_write(11'h404, 32'h5A5A_0002);
        bus_write(11'h5FC, 32'hCAFE_F00D);
        bus_read(11'h400, 32'hA5A5_0001, "R7 first word");
        bus_read(11'h404, 32'h5A5A_0002, "R7 second word");
        bus_read(11'h5FC, 32'hCAFE_F00D, "R7 last word");
        drain();

        // R9 unmapped and misaligned
        bus_write(11'h050, 32'hFFFF_FFFF);
        bus_write(11'h600, 32'h1111_1111);
        bus_write(11'h011, 32'h0000_0055);
        bus_read(11'h050, 32'h0, "R9 unmapped low read");
        bus_read(11'h600, 32'h0, "R9 unmapped high read");
        bus_read(11'h00D, 32'h0, "R9 misaligned read");
        bus_read(11'h400, 32'hA5A5_0001, "R9 window untouched");
        bus_read(11'h010, 32'h0C, "R9 ipgr1 untouched");
        bus_read(11'h04C, 32'h0123_4567, "R9 hash high untouched");
        drain();

        // R8 start/stop pulses
        bus_write(11'h000, 32'h0000_A003);
        check("R8 both start", 64'({rx_start_o, rx_stop_o, tx_start_o, tx_stop_o}), 64'b1010);
        bus_write(11'h000, 32'h0000_A003);
        check("R8 unchanged no pulse", 64'({rx_start_o, rx_stop_o, tx_start_o, tx_stop_o}), 64'b0000);
        bus_write(11'h000, 32'h0000_A001);
        check("R8 tx stop only", 64'({rx_start_o, rx_stop_o, tx_start_o, tx_stop_o}), 64'b0001);
        @(posedge clk); #1;
        check("R8 pulse one cycle", 64'(tx_stop_o), 64'd0);

        // R5 self-reset
        bus_write(11'h000, 32'h0000_0801);
        check("R5 mode after self-reset", 64'(mode_o), 64'hA000);
        check("R5 rx stop on self-reset", 64'({rx_start_o, rx_stop_o, tx_start_o, tx_stop_o}), 64'b0100);
        check("R5 ring idx restored", 64'(rx_ring_idx_o), 64'h080);
        check("R5 int src cleared", 64'(int_src_o), 64'h0);
        check("R5 station cleared", 64'(station_addr_o), 64'h0);
        bus_read(11'h020, 32'h40, "R5 txbd restored");
        bus_read(11'h008, 32'h0, "R5 int mask cleared");
        bus_read(11'h018, 32'h003C_0600, "R5 pktlen restored");
        bus_read(11'h400, 32'hA5A5_0001, "R5 descriptor kept");
        drain();

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule